// File: doc/BRIEF.md
# I2C Target Interface with Transfer Status

This block is the target (slave) side of a two-wire serial bus in the I2C/SMBus style. It watches the clock and data lines through synchronizers and finds START and STOP conditions. It takes in the 7-bit address byte and compares it with a programmable own-address. On a match it acknowledges and then enters receive mode (R/W clear) or transmit mode (R/W set). A mismatch leaves the data line released until the next START.

Software, or a DMA engine, reaches the block through a small register port. Outgoing bytes go into a transmit holding register, and incoming bytes come from a receive register. A status word reports separate events: transmit-ready, byte finished, not-acknowledge, direction, transfer complete and last byte. Any status bit can raise the interrupt line through an enable mask. A loadable byte counter counts completed bytes down and marks the byte that takes it to zero. This lets the final byte of a packet, such as a packet-error-check byte, be told apart. The transmit-ready bit also drives the DMA transmit request.

Top module: `i2c_tgt`

Register offsets: 0 own address (bits 6:0), 1 transmit holding (write), 2 receive data (read), 3 status (read), 4 status clear (write), 5 interrupt enable, 6 byte count. Status bits: 0 transmit-ready, 1 byte-finished, 2 not-acknowledge, 3 direction (1 = target transmits), 4 transfer complete, 5 last byte.

## Requirements
- R1: After reset, status reads 0x01 (only transmit-ready set), `sda_oe` is low, `irq` is low and `dma_tx_req` is high.
- R2: An address byte equal to the own address with R/W = 0 is acknowledged by holding SDA low through the ninth clock, and status bit 3 reads 0 afterwards.
- R3: An address byte equal to the own address with R/W = 1 is acknowledged, status bit 3 reads 1, and the byte in the transmit holding register is shifted out MSB first, with each later byte taken from the register at the end of the previous acknowledge clock.
- R4: A mismatching address is not acknowledged, and SDA is never pulled low until the next START. Status and receive data are left unchanged, and the following STOP does not set bit 4.
- R5: In receive mode every byte (MSB first) is acknowledged, it appears at offset 2, and status bit 1 is set.
- R6: After a transmitted byte the target releases SDA during the acknowledge clock. If the controller leaves SDA high there, status bit 2 is set.
- R7: Writing offset 1 clears status bit 0 and `dma_tx_req` on the next cycle. Moving the holding register into the shifter sets them again.
- R8: A STOP that ends a transfer addressed to this target sets status bit 4.
- R9: The byte counter at offset 6 decrements by one on each completed data byte and never drops below zero. The byte that moves it from 1 to 0 sets status bit 5.
- R10: Writing 1s to offset 4 clears the matching bits among 1, 2, 4 and 5. Bits 0 and 3 are not affected by such writes.
- R11: `irq` is high exactly when some status bit is set whose bit at offset 5 is also set.
- R12: The target changes `sda_oe` only while the synchronized SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit holding register can accept a byte |

## Verification
A wrong bit position or state in the byte engine shows up at the controller within one byte time. It appears either as a missing or extra low level in the ninth clock slot, or as a received byte whose bits are shifted. A status flag that is set or cleared wrongly shows on the status read taken right after each byte and each STOP, well before the next byte begins. A counter that is off by one moves the last-byte flag to a neighbouring byte. A mistake in the transmit hand-off repeats or skips a byte in the stream the controller reads back.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_TNEXT
  } tgt_st_e;

  localparam int unsigned RA_W = 3;

  localparam logic [RA_W-1:0] OFS_OWN  = 3'd0;
  localparam logic [RA_W-1:0] OFS_THR  = 3'd1;
  localparam logic [RA_W-1:0] OFS_RHR  = 3'd2;
  localparam logic [RA_W-1:0] OFS_STAT = 3'd3;
  localparam logic [RA_W-1:0] OFS_CLR  = 3'd4;
  localparam logic [RA_W-1:0] OFS_IEN  = 3'd5;
  localparam logic [RA_W-1:0] OFS_CNT  = 3'd6;

  localparam int unsigned NSTAT    = 6;
  localparam int unsigned SB_TXRDY = 0;
  localparam int unsigned SB_BTF   = 1;
  localparam int unsigned SB_NAK   = 2;
  localparam int unsigned SB_DIR   = 3;
  localparam int unsigned SB_DONE  = 4;
  localparam int unsigned SB_LAST  = 5;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0]        rst_pipe;
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_tgt_bcnt.sv
module i2c_tgt_bcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         hit
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign hit   = dec && !load && (cnt_q == W'(1));

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_tx_req
);

  localparam int unsigned BC_W = $clog2(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);
  localparam logic [NSTAT-1:0] CLR_MASK =
    NSTAT'((1 << SB_BTF) | (1 << SB_NAK) | (1 << SB_DONE) | (1 << SB_LAST));
  localparam logic [NSTAT-1:0] STAT_RST = NSTAT'(1 << SB_TXRDY);

  logic rst_s_n, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_an(rst_n), .rst_sn(rst_s_n),
    .scl_i(scl_i), .sda_i(sda_i), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_st_e           st_q, st_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic [DATA_W-1:0] tx_q, tx_d, rhr_q, rhr_d, thr_q;
  logic              oe_q, oe_d, ack_q, ack_d, act_q, act_d;
  logic [ADDR_W-1:0] own_q;
  logic [NSTAT-1:0]  ien_q, sts_q, sts_d;
  logic ev_btf, ev_nak, ev_done, ev_load, ev_byte, dir_set, dir_clr;
  logic wr_own, wr_thr, wr_clr, wr_ien, wr_cnt;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_hit;

  assign wr_own = reg_we && reg_addr == OFS_OWN;
  assign wr_thr = reg_we && reg_addr == OFS_THR;
  assign wr_clr = reg_we && reg_addr == OFS_CLR;
  assign wr_ien = reg_we && reg_addr == OFS_IEN;
  assign wr_cnt = reg_we && reg_addr == OFS_CNT;

  i2c_tgt_bcnt #(.W(CNT_W)) u_bcnt (
    .clk(clk), .rst_n(rst_s_n), .load(wr_cnt),
    .load_val(reg_wdata[CNT_W-1:0]), .dec(ev_byte),
    .count(cnt_val), .hit(cnt_hit)
  );

  // byte engine: sample on SCL rise, drive on SCL fall
  always_comb begin
    st_d = st_q;  bit_d = bit_q; sh_d = sh_q;  tx_d = tx_q;
    oe_d = oe_q;  ack_d = ack_q; act_d = act_q; rhr_d = rhr_q;
    ev_btf = 1'b0; ev_nak = 1'b0; ev_done = 1'b0; ev_load = 1'b0;
    ev_byte = 1'b0; dir_set = 1'b0; dir_clr = 1'b0;
    if (start_det) begin
      st_d = ST_ADDR; bit_d = '0; oe_d = 1'b0; ack_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0; ack_d = 1'b0; act_d = 1'b0; ev_done = act_q;
    end else begin
      case (st_q)
        ST_ADDR: if (scl_rise) begin
          sh_d  = {sh_q[DATA_W-3:0], sda_s};
          bit_d = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            bit_d = '0;
            if (sh_q[ADDR_W-1:0] == own_q) begin
              st_d = ST_AACK; act_d = 1'b1; dir_set = sda_s; dir_clr = !sda_s;
            end else begin
              st_d = ST_IDLE; act_d = 1'b0;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!ack_q) begin
            oe_d = 1'b1; ack_d = 1'b1;
          end else begin
            ack_d = 1'b0;
            if (sts_q[SB_DIR]) begin
              st_d = ST_TX; tx_d = thr_q; oe_d = !thr_q[DATA_W-1]; ev_load = 1'b1;
            end else begin
              st_d = ST_RX; oe_d = 1'b0;
            end
          end
        end
        ST_RX: if (scl_rise) begin
          sh_d  = {sh_q[DATA_W-3:0], sda_s};
          bit_d = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            bit_d = '0; rhr_d = {sh_q, sda_s}; ev_btf = 1'b1; ev_byte = 1'b1;
            st_d = ST_RACK; ack_d = 1'b0;
          end
        end
        ST_RACK: if (scl_fall) begin
          if (!ack_q) begin
            oe_d = 1'b1; ack_d = 1'b1;
          end else begin
            oe_d = 1'b0; ack_d = 1'b0; st_d = ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 1'b1;
            if (bit_q == LAST_BIT) begin
              bit_d = '0; st_d = ST_TACK; ack_d = 1'b0;
            end
          end else if (scl_fall) begin
            tx_d = {tx_q[DATA_W-2:0], tx_q[DATA_W-1]};
            oe_d = !tx_q[DATA_W-2];
          end
        end
        ST_TACK: begin
          if (scl_fall && !ack_q) begin
            oe_d = 1'b0; ack_d = 1'b1;
          end else if (scl_rise && ack_q) begin
            ack_d = 1'b0; ev_byte = 1'b1;
            if (sda_s) begin
              ev_nak = 1'b1; st_d = ST_IDLE;
            end else begin
              st_d = ST_TNEXT;
            end
          end
        end
        ST_TNEXT: if (scl_fall) begin
          st_d = ST_TX; bit_d = '0; tx_d = thr_q; oe_d = !thr_q[DATA_W-1]; ev_load = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // status word: events set, write-one clears, holding-register write wins
  always_comb begin
    sts_d = sts_q;
    if (wr_clr)  sts_d = sts_q & ~(reg_wdata[NSTAT-1:0] & CLR_MASK);
    if (ev_btf)  sts_d[SB_BTF]  = 1'b1;
    if (ev_nak)  sts_d[SB_NAK]  = 1'b1;
    if (ev_done) sts_d[SB_DONE] = 1'b1;
    if (cnt_hit) sts_d[SB_LAST] = 1'b1;
    if (dir_set)      sts_d[SB_DIR] = 1'b1;
    else if (dir_clr) sts_d[SB_DIR] = 1'b0;
    if (wr_thr)       sts_d[SB_TXRDY] = 1'b0;
    else if (ev_load) sts_d[SB_TXRDY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      tx_q  <= '0;
      oe_q  <= 1'b0;
      ack_q <= 1'b0;
      act_q <= 1'b0;
      rhr_q <= '0;
      sts_q <= STAT_RST;
      own_q <= RESET_ADDR;
      thr_q <= '0;
      ien_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
      oe_q  <= oe_d;
      ack_q <= ack_d;
      act_q <= act_d;
      rhr_q <= rhr_d;
      sts_q <= sts_d;
      if (wr_own) own_q <= reg_wdata[ADDR_W-1:0];
      if (wr_thr) thr_q <= reg_wdata;
      if (wr_ien) ien_q <= reg_wdata[NSTAT-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_OWN:  reg_rdata = DATA_W'(own_q);
      OFS_THR:  reg_rdata = thr_q;
      OFS_RHR:  reg_rdata = rhr_q;
      OFS_STAT: reg_rdata = DATA_W'(sts_q);
      OFS_IEN:  reg_rdata = DATA_W'(ien_q);
      OFS_CNT:  reg_rdata = DATA_W'(cnt_val);
      default:  reg_rdata = '0;
    endcase
  end

  assign sda_oe     = oe_q;
  assign irq        = |(sts_q & ien_q);
  assign dma_tx_req = sts_q[SB_TXRDY];

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              sda_oe,
  input logic              irq,
  input logic              dma_tx_req,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              done_flag,
  input logic [CNT_W-1:0]  cnt
);

  AST_THR_WR_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_THR) |=> !dma_tx_req); // R7

  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_IEN && reg_wdata == '0) |=> !irq); // R11

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_CLR && reg_wdata[SB_DONE] && !stop_det) |=> !done_flag); // R10

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !(reg_we && reg_addr == OFS_CNT)) |=> cnt == '0); // R9

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R12

endmodule

bind i2c_tgt i2c_tgt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sda_oe(sda_oe), .irq(irq), .dma_tx_req(dma_tx_req),
  .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .done_flag(sts_q[SB_DONE]), .cnt(cnt_val)
);

// File: tb/tb_i2c_tgt.sv
module tb_i2c_tgt;
  import i2c_tgt_pkg::*;

  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h35;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_line, sda_oe, irq, dma, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tgt dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .dma_tx_req(dma)
  );

  int nchk = 0, nerr = 0;
  bit fin = 0, watch = 0, pulled = 0;

  always @(posedge clk) if (watch && sda_oe) pulled = 1;

  function automatic logic exp_irq(input logic [7:0] st, input logic [7:0] en);
    return |(st[5:0] & en[5:0]);
  endfunction

  function automatic logic exp_last(input int cm);
    return cm == 1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b, output logic smp);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); smp = sda_line; scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i], s);
    put_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic rd_byte(input bit more, input logic [7:0] nxt,
                         output logic [7:0] d, output logic ack_slot);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      d[i] = s;
      if (i == 7) begin
        chk("R7 ready after hand-off", dma, 1);
        if (more) begin
          reg_wr(OFS_THR, nxt);
          chk("R7 ready drops on write", dma, 0);
        end
      end
    end
    put_bit(more ? 1'b0 : 1'b1, ack_slot);
  endtask

  task automatic rx_xfer(input int len, input int cl);
    logic ack; logic [7:0] d, st, v; int cm;
    reg_wr(OFS_CNT, 8'(cl)); cm = cl;
    bus_start();
    wr_byte({OWN, 1'b0}, ack);
    chk("R2 address acked", ack, 1);
    rd(OFS_STAT, st); chk("R2 direction clear", st[SB_DIR], 0);
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      wr_byte(d, ack);
      chk("R5 data acked", ack, 1);
      rd(OFS_STAT, st);
      chk("R5 byte finished", st[SB_BTF], 1);
      chk("R9 last flag rx", st[SB_LAST], exp_last(cm));
      if (cm > 0) cm--;
      rd(OFS_RHR, v); chk("R5 received byte", v, d);
      rd(OFS_CNT, v); chk("R9 count rx", v, cm);
      reg_wr(OFS_CLR, 8'h22);
    end
    bus_stop();
  endtask

  task automatic tx_xfer(input int len, input int cl);
    logic ack, s; logic [7:0] d, st, v; logic [7:0] b [4]; int cm;
    for (int k = 0; k < 4; k++) b[k] = 8'($urandom);
    reg_wr(OFS_CNT, 8'(cl)); cm = cl;
    reg_wr(OFS_THR, b[0]);
    chk("R7 request low after write", dma, 0);
    bus_start();
    wr_byte({OWN, 1'b1}, ack);
    chk("R3 address acked", ack, 1);
    rd(OFS_STAT, st); chk("R3 direction set", st[SB_DIR], 1);
    for (int k = 0; k < len; k++) begin
      rd_byte(k < len - 1, (k < len - 1) ? b[k+1] : 8'h00, d, s);
      chk("R3 transmitted byte", d, b[k]);
      rd(OFS_STAT, st);
      chk("R9 last flag tx", st[SB_LAST], exp_last(cm));
      if (cm > 0) cm--;
      rd(OFS_CNT, v); chk("R9 count tx", v, cm);
      reg_wr(OFS_CLR, 8'h20);
      if (k == len - 1) begin
        chk("R6 SDA released on ack clock", s, 1);
        rd(OFS_STAT, st); chk("R6 nak flag", st[SB_NAK], 1);
      end
    end
    bus_stop();
  endtask

  task automatic end_xfer();
    logic [7:0] st;
    rd(OFS_STAT, st); chk("R8 transfer complete", st[SB_DONE], 1);
    reg_wr(OFS_CLR, 8'h3E);
    rd(OFS_STAT, st); chk("R10 clearable bits gone", st & 8'h36, 0);
  endtask

  initial begin
    logic [7:0] st, st0, rh0, en;
    logic ack;
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(5); rst_n = 1'b1; tick(5);

    rd(OFS_STAT, st);
    chk("R1 reset status", st, 8'h01);
    chk("R1 reset sda", sda_oe, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset request", dma, 1);

    reg_wr(OFS_OWN, {1'b0, OWN});

    // counter at 1 over two bytes: flag on first, floor on second
    rx_xfer(2, 1);
    end_xfer();

    tx_xfer(1, 1);
    rd(OFS_STAT, st);
    for (int i = 0; i < 6; i++) begin
      en = (i == 5) ? 8'h00 : 8'(1 << i);
      reg_wr(OFS_IEN, en);
      chk("R11 irq vs mask", irq, exp_irq(st, en));
    end
    reg_wr(OFS_CLR, 8'hFF);
    rd(OFS_STAT, st);
    chk("R10 bits 0 and 3 kept", st, 8'h09);
    reg_wr(OFS_IEN, 8'h04);
    chk("R11 irq off after clear", irq, 0);
    reg_wr(OFS_IEN, 8'h00);

    // wrong address
    rd(OFS_STAT, st0); rd(OFS_RHR, rh0);
    pulled = 0; watch = 1;
    bus_start();
    wr_byte({OWN ^ 7'h01, 1'b0}, ack);
    chk("R4 no ack on mismatch", ack, 0);
    wr_byte(8'h5A, ack);
    chk("R4 data ignored", ack, 0);
    bus_stop();
    watch = 0;
    chk("R4 SDA never pulled", pulled, 0);
    rd(OFS_STAT, st); chk("R4 status unchanged", st, st0);
    rd(OFS_RHR, st); chk("R4 receive data unchanged", st, rh0);

    for (int t = 0; t < 8; t++) begin
      int len, cl;
      len = 1 + int'($urandom % 4);
      cl  = int'($urandom % 6);
      if ($urandom % 2 == 0) rx_xfer(len, cl);
      else                   tx_xfer(len, cl);
      end_xfer();
    end

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule